// File: doc/BRIEF.md
# Regulator Rail Control Register Bank

This block is the register file behind a multi-rail linear regulator. A host reaches it over a simple synchronous register bus made of an address, write data, a write strobe and combinational read data. Through this bus the host sets the output-voltage code of each of five rails (core, pad, analog, oscillator and motor), switches rails on and off, and selects whether each rail's output is actively pulled down by a discharge switch while that rail is off.

The oscillator and motor rails have two enable sources: a register bit and an external pin. They are ORed, so either source can hold the rail on. Two strap pins choose the power-up voltage codes of the core and pad rails. The block captures them only while reset is held, so changing them later has no effect. Bit 7 of address 0 is a sticky "defaults loaded" flag. Reset sets it. The bus can clear it but never set it. A host clears the flag after it has configured the block and reads it back later: if it reads 1 again, a reset has occurred in between.

Top module: `ldo_regbank`

## Requirements
- R1: While `rst` is high at a rising edge, the block loads these defaults. The flag (address 0 bit 7) becomes 1. The core, pad and analog register enables (address 2 bits 0, 1, 2) become 1 and the motor register enable (address 2 bit 6) becomes 0. The oscillator register enable (address 6 bit 3) becomes 1. All five discharge bits (address 7 bits 4:0) become 1. The analog, oscillator and motor codes at addresses 3, 4 and 5 become 0x50, 0x5A and 0x58.
- R2: Reset sets the core code (address 1, bits 6:0) to 0x30 when `coreSelPin` is high and to 0x1E when it is low. It sets the pad code (address 0, bits 6:0) to 0x60 when `padSelPin` is high and to 0x40 when it is low.
- R3: After reset ends, a change on `coreSelPin` or `padSelPin` leaves both codes unchanged. Only a bus write to address 1 or address 0 changes them.
- R4: A write to address 0 always loads bits 6:0 into the pad code. If write-data bit 7 is 0, the write clears the flag. If bit 7 is 1, the flag is left as it was, so writing 0xFF to a cleared flag reads back 0x7F.
- R5: Asserting reset after the flag has been cleared sets the flag back to 1.
- R6: The oscillator rail (`railEnOut[3]`) is on when address 6 bit 3 is 1 or `tcxoEnPin` is high. It is off only when both are off.
- R7: The motor rail (`railEnOut[4]`) is on when address 2 bit 6 is 1 or `motEnPin` is high. Rails 0, 1 and 2 (core, pad, analog) follow address 2 bits 0, 1 and 2.
- R8: `dischargeOut[i]` is 1 exactly when rail i is off and discharge bit i (address 7, bit i) is 1. The bit order is core, pad, analog, oscillator, motor from bit 0.
- R9: Address 8 is a read-only status register. Bit 0 reads the `tcxoEnPin` level, bit 2 reads the `motEnPin` level, and the other bits read 0. Writes to address 8 change nothing.
- R10: Reads of addresses 9 to 15 return 0, and writes to them change no register and no output.
- R11: Register bits that are not listed above read as 0, and writing to them has no effect. For example, writing 0xFF to address 6 reads back 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap pins are captured while it is held |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe; the write takes effect at the rising edge |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| coreSelPin | input | 1 | Core default-code strap |
| padSelPin | input | 1 | Pad default-code strap |
| tcxoEnPin | input | 1 | External enable for the oscillator rail |
| motEnPin | input | 1 | External enable for the motor rail |
| railEnOut | output | 5 | Per-rail enable (core, pad, analog, oscillator, motor) |
| dischargeOut | output | 5 | Per-rail discharge-switch control |

## Verification
Every piece of stored state can be read back, so a wrong register value shows up on `regRdData` on the same cycle that its address is presented. A wrong enable or discharge bit shows up at once on `railEnOut` and `dischargeOut`. A flag that was wrongly set or not cleared, or a code that followed a strap pin after reset, is found by the read that follows the relevant write or pin change. A corrupted enable is also found by looking at the rail outputs with the external pins held low.

// File: rtl/ldo_regbank_pkg.sv
package ldo_regbank_pkg;

  localparam int NUM_RAILS = 5;
  localparam int CODE_W    = 7;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;

  // Rail indices; discharge bit i and railEnOut[i] follow this order
  localparam int RAIL_CORE = 0;
  localparam int RAIL_PAD  = 1;
  localparam int RAIL_ANA  = 2;
  localparam int RAIL_TCXO = 3;
  localparam int RAIL_MOT  = 4;

  // Register addresses
  localparam logic [ADDR_W-1:0] ADR_PAD    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CORE   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_EN     = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ANA    = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_TCXO   = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_MOT    = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_OSCEN  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_DISCH  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 4'd8;

  // Bit positions inside shared registers
  localparam int BIT_FLAG   = 7;
  localparam int BIT_MOTEN  = 6;
  localparam int BIT_OSCEN  = 3;
  localparam int BIT_ST_OSC = 0;
  localparam int BIT_ST_MOT = 2;

  typedef struct packed {
    logic padFlag;
    logic coreCode;
    logic railEn;
    logic anaCode;
    logic tcxoCode;
    logic motCode;
    logic oscEn;
    logic disch;
  } wrStrobeT;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_PAD,
    RD_CORE,
    RD_EN,
    RD_ANA,
    RD_TCXO,
    RD_MOT,
    RD_OSCEN,
    RD_DISCH,
    RD_STATUS
  } rdSelT;

endpackage

// File: rtl/ldo_regbank_ctrl.sv
module ldo_regbank_ctrl
  import ldo_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output wrStrobeT          wrStb,
  output rdSelT             rdSel
);

  always_comb begin
    wrStb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        ADR_PAD:   wrStb.padFlag  = 1'b1;
        ADR_CORE:  wrStb.coreCode = 1'b1;
        ADR_EN:    wrStb.railEn   = 1'b1;
        ADR_ANA:   wrStb.anaCode  = 1'b1;
        ADR_TCXO:  wrStb.tcxoCode = 1'b1;
        ADR_MOT:   wrStb.motCode  = 1'b1;
        ADR_OSCEN: wrStb.oscEn    = 1'b1;
        ADR_DISCH: wrStb.disch    = 1'b1;
        default:   wrStb = '0;  // status and unmapped: no write
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      ADR_PAD:    rdSel = RD_PAD;
      ADR_CORE:   rdSel = RD_CORE;
      ADR_EN:     rdSel = RD_EN;
      ADR_ANA:    rdSel = RD_ANA;
      ADR_TCXO:   rdSel = RD_TCXO;
      ADR_MOT:    rdSel = RD_MOT;
      ADR_OSCEN:  rdSel = RD_OSCEN;
      ADR_DISCH:  rdSel = RD_DISCH;
      ADR_STATUS: rdSel = RD_STATUS;
      default:    rdSel = RD_NONE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wrStb)); // R10
  AST_STATUS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (regAddr >= ADR_STATUS) |-> (wrStb == '0)); // R9

endmodule

// File: rtl/ldo_regbank_dp.sv
module ldo_regbank_dp
  import ldo_regbank_pkg::*;
#(
  parameter logic [CODE_W-1:0] CORE_CODE_LO = 7'h1E,
  parameter logic [CODE_W-1:0] CORE_CODE_HI = 7'h30,
  parameter logic [CODE_W-1:0] PAD_CODE_LO  = 7'h40,
  parameter logic [CODE_W-1:0] PAD_CODE_HI  = 7'h60,
  parameter logic [CODE_W-1:0] ANA_CODE_DEF = 7'h50,
  parameter logic [CODE_W-1:0] OSC_CODE_DEF = 7'h5A,
  parameter logic [CODE_W-1:0] MOT_CODE_DEF = 7'h58
)(
  input  logic                 clk,
  input  logic                 rst,
  input  wrStrobeT             wrStb,
  input  rdSelT                rdSel,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 coreSelPin,
  input  logic                 padSelPin,
  input  logic                 tcxoEnPin,
  input  logic                 motEnPin,
  output logic [NUM_RAILS-1:0] railEnOut,
  output logic [NUM_RAILS-1:0] dischargeOut
);

  localparam int PAD_W = DATA_W - CODE_W;

  logic                 flagQ;
  logic [CODE_W-1:0]    padCodeQ, coreCodeQ, anaCodeQ, oscCodeQ, motCodeQ;
  logic [2:0]           baseEnQ;
  logic                 motEnQ;
  logic                 oscEnQ;
  logic [NUM_RAILS-1:0] dischQ;
  logic [NUM_RAILS-1:0] railOn;

  // Sticky flag: set only by reset, cleared by a write with bit 7 low
  always_ff @(posedge clk) begin
    if (rst)
      flagQ <= 1'b1;
    else if (wrStb.padFlag && !regWrData[BIT_FLAG])
      flagQ <= 1'b0;
  end

  // Strap-selected codes are captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      padCodeQ  <= padSelPin  ? PAD_CODE_HI  : PAD_CODE_LO;
      coreCodeQ <= coreSelPin ? CORE_CODE_HI : CORE_CODE_LO;
    end else begin
      if (wrStb.padFlag)  padCodeQ  <= regWrData[CODE_W-1:0];
      if (wrStb.coreCode) coreCodeQ <= regWrData[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      anaCodeQ <= ANA_CODE_DEF;
      oscCodeQ <= OSC_CODE_DEF;
      motCodeQ <= MOT_CODE_DEF;
    end else begin
      if (wrStb.anaCode)  anaCodeQ <= regWrData[CODE_W-1:0];
      if (wrStb.tcxoCode) oscCodeQ <= regWrData[CODE_W-1:0];
      if (wrStb.motCode)  motCodeQ <= regWrData[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseEnQ <= '1;
      motEnQ  <= 1'b0;
      oscEnQ  <= 1'b1;
      dischQ  <= '1;
    end else begin
      if (wrStb.railEn) begin
        baseEnQ <= regWrData[2:0];
        motEnQ  <= regWrData[BIT_MOTEN];
      end
      if (wrStb.oscEn) oscEnQ <= regWrData[BIT_OSCEN];
      if (wrStb.disch) dischQ <= regWrData[NUM_RAILS-1:0];
    end
  end

  // Rail enables: register bits, with pin OR for the two pin-controlled rails
  always_comb begin
    railOn            = '0;
    railOn[2:0]       = baseEnQ;
    railOn[RAIL_TCXO] = oscEnQ | tcxoEnPin;
    railOn[RAIL_MOT]  = motEnQ | motEnPin;
  end

  assign railEnOut = railOn;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_disch
    assign dischargeOut[i] = dischQ[i] & ~railOn[i];
  end

  always_comb begin
    regRdData = '0;
    unique case (rdSel)
      RD_PAD:    regRdData = {flagQ, padCodeQ};
      RD_CORE:   regRdData = {{PAD_W{1'b0}}, coreCodeQ};
      RD_EN:     begin
                   regRdData[2:0]       = baseEnQ;
                   regRdData[BIT_MOTEN] = motEnQ;
                 end
      RD_ANA:    regRdData = {{PAD_W{1'b0}}, anaCodeQ};
      RD_TCXO:   regRdData = {{PAD_W{1'b0}}, oscCodeQ};
      RD_MOT:    regRdData = {{PAD_W{1'b0}}, motCodeQ};
      RD_OSCEN:  regRdData[BIT_OSCEN] = oscEnQ;
      RD_DISCH:  regRdData[NUM_RAILS-1:0] = dischQ;
      RD_STATUS: begin
                   regRdData[BIT_ST_OSC] = tcxoEnPin;
                   regRdData[BIT_ST_MOT] = motEnPin;
                 end
      default:   regRdData = '0;
    endcase
  end

  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !flagQ |=> !flagQ); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wrStb.padFlag && !regWrData[BIT_FLAG]) |=> !flagQ); // R4
  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrStb.coreCode |=> $stable(coreCodeQ)); // R3
  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrStb.padFlag |=> $stable(padCodeQ)); // R3
  AST_OSC_PIN_ON: assert property (@(posedge clk) disable iff (rst)
    tcxoEnPin |-> railEnOut[RAIL_TCXO]); // R6
  AST_MOT_PIN_ON: assert property (@(posedge clk) disable iff (rst)
    motEnPin |-> railEnOut[RAIL_MOT]); // R7
  AST_DISCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    (railEnOut & dischargeOut) == '0); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdSel == RD_NONE) |-> (regRdData == '0)); // R10

endmodule

// File: rtl/ldo_regbank.sv
module ldo_regbank
  import ldo_regbank_pkg::*;
#(
  parameter logic [CODE_W-1:0] CORE_CODE_LO = 7'h1E,
  parameter logic [CODE_W-1:0] CORE_CODE_HI = 7'h30,
  parameter logic [CODE_W-1:0] PAD_CODE_LO  = 7'h40,
  parameter logic [CODE_W-1:0] PAD_CODE_HI  = 7'h60,
  parameter logic [CODE_W-1:0] ANA_CODE_DEF = 7'h50,
  parameter logic [CODE_W-1:0] OSC_CODE_DEF = 7'h5A,
  parameter logic [CODE_W-1:0] MOT_CODE_DEF = 7'h58
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regWrEn,
  output logic [DATA_W-1:0]    regRdData,
  input  logic                 coreSelPin,
  input  logic                 padSelPin,
  input  logic                 tcxoEnPin,
  input  logic                 motEnPin,
  output logic [NUM_RAILS-1:0] railEnOut,
  output logic [NUM_RAILS-1:0] dischargeOut
);

  wrStrobeT wrStb;
  rdSelT    rdSel;

  ldo_regbank_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .wrStb   (wrStb),
    .rdSel   (rdSel)
  );

  ldo_regbank_dp #(
    .CORE_CODE_LO (CORE_CODE_LO),
    .CORE_CODE_HI (CORE_CODE_HI),
    .PAD_CODE_LO  (PAD_CODE_LO),
    .PAD_CODE_HI  (PAD_CODE_HI),
    .ANA_CODE_DEF (ANA_CODE_DEF),
    .OSC_CODE_DEF (OSC_CODE_DEF),
    .MOT_CODE_DEF (MOT_CODE_DEF)
  ) dp_i (
    .clk          (clk),
    .rst          (rst),
    .wrStb        (wrStb),
    .rdSel        (rdSel),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .coreSelPin   (coreSelPin),
    .padSelPin    (padSelPin),
    .tcxoEnPin    (tcxoEnPin),
    .motEnPin     (motEnPin),
    .railEnOut    (railEnOut),
    .dischargeOut (dischargeOut)
  );

endmodule

// File: tb/ldo_regbank_tb_top.sv
`timescale 1ns/1ps
module ldo_regbank_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       coreSelPin = 1'b0;
  logic       padSelPin = 1'b1;
  logic       tcxoEnPin = 1'b0;
  logic       motEnPin = 1'b0;
  logic [4:0] railEnOut;
  logic [4:0] dischargeOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ldo_regbank dut_i (
    .clk          (clk),
    .rst          (rst),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regWrEn      (regWrEn),
    .regRdData    (regRdData),
    .coreSelPin   (coreSelPin),
    .padSelPin    (padSelPin),
    .tcxoEnPin    (tcxoEnPin),
    .motEnPin     (motEnPin),
    .railEnOut    (railEnOut),
    .dischargeOut (dischargeOut)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic doReset(input logic coreS, input logic padS);
    @(negedge clk);
    coreSelPin = coreS;
    padSelPin  = padS;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    doRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic expectOuts(input string tag, input logic [4:0] en, input logic [4:0] dis);
    #1;
    check({tag, " railEnOut"}, {3'b0, railEnOut}, {3'b0, en});
    check({tag, " dischargeOut"}, {3'b0, dischargeOut}, {3'b0, dis});
  endtask

  task automatic testResetDefaults();
    doReset(1'b0, 1'b1);
    expectReg("R1 R2 reg0 flag+pad hi", 4'd0, 8'hE0);
    expectReg("R2 reg1 core lo", 4'd1, 8'h1E);
    expectReg("R1 reg2 enables", 4'd2, 8'h07);
    expectReg("R1 reg3", 4'd3, 8'h50);
    expectReg("R1 reg4", 4'd4, 8'h5A);
    expectReg("R1 reg5", 4'd5, 8'h58);
    expectReg("R1 reg6", 4'd6, 8'h08);
    expectReg("R1 reg7", 4'd7, 8'h1F);
    expectOuts("R1 R8 defaults", 5'b01111, 5'b10000);
  endtask

  task automatic testStrapHold();
    @(negedge clk);
    coreSelPin = 1'b1; padSelPin = 1'b0;
    repeat (2) @(negedge clk);
    expectReg("R3 core after strap change", 4'd1, 8'h1E);
    expectReg("R3 pad after strap change", 4'd0, 8'hE0);
    doWrite(4'd1, 8'h33);
    expectReg("R3 core written", 4'd1, 8'h33);
    doWrite(4'd3, 8'hA2);
    expectReg("R11 reg3 upper bit", 4'd3, 8'h22);
  endtask

  task automatic testFlag();
    doWrite(4'd0, 8'h85);
    expectReg("R4 write bit7=1 keeps flag", 4'd0, 8'h85);
    doWrite(4'd0, 8'h05);
    expectReg("R4 write bit7=0 clears", 4'd0, 8'h05);
    doWrite(4'd0, 8'hFF);
    expectReg("R4 0xFF after clear", 4'd0, 8'h7F);
    doReset(1'b1, 1'b0);
    expectReg("R5 R2 flag back, pad lo", 4'd0, 8'hC0);
    expectReg("R2 core hi", 4'd1, 8'h30);
  endtask

  task automatic testOsc();
    doReset(1'b0, 1'b0);
    tcxoEnPin = 1'b0;
    expectOuts("R6 reg on pin off", 5'b01111, 5'b10000);
    doWrite(4'd6, 8'hFF);
    expectReg("R11 reg6 only bit3", 4'd6, 8'h08);
    doWrite(4'd6, 8'h00);
    expectOuts("R6 both off", 5'b00111, 5'b11000);
    @(negedge clk); tcxoEnPin = 1'b1;
    expectOuts("R6 pin on", 5'b01111, 5'b10000);
    expectReg("R9 status osc pin", 4'd8, 8'h01);
    @(negedge clk); tcxoEnPin = 1'b0;
  endtask

  task automatic testMot();
    doWrite(4'd2, 8'h47);
    expectOuts("R7 mot reg on", 5'b10111, 5'b01000);
    expectReg("R7 reg2 readback", 4'd2, 8'h47);
    doWrite(4'd2, 8'h02);
    expectOuts("R7 mot off core/ana off", 5'b00010, 5'b11101);
    @(negedge clk); motEnPin = 1'b1;
    expectOuts("R7 mot pin on", 5'b10010, 5'b01101);
    expectReg("R9 status mot pin", 4'd8, 8'h04);
    @(negedge clk); motEnPin = 1'b0;
  endtask

  task automatic testDischarge();
    doWrite(4'd7, 8'h00);
    expectOuts("R8 discharge all off", 5'b00010, 5'b00000);
    doWrite(4'd7, 8'hE1);
    expectReg("R8 reg7 readback", 4'd7, 8'h01);
    expectOuts("R8 core discharge", 5'b00010, 5'b00001);
  endtask

  task automatic testStatusUnmapped();
    logic [7:0] d;
    @(negedge clk); tcxoEnPin = 1'b1; motEnPin = 1'b1;
    expectReg("R9 status both", 4'd8, 8'h05);
    doWrite(4'd8, 8'h00);
    doWrite(4'd12, 8'hFF);
    doWrite(4'd15, 8'h00);
    expectReg("R9 status after write", 4'd8, 8'h05);
    expectReg("R10 reg0 untouched", 4'd0, 8'hC0);
    expectReg("R10 reg2 untouched", 4'd2, 8'h02);
    expectReg("R10 reg7 untouched", 4'd7, 8'h01);
    for (int a = 9; a < 16; a++) begin
      doRead(a[3:0], d);
      check($sformatf("R10 read addr %0d", a), d, 8'h00);
    end
    @(negedge clk); tcxoEnPin = 1'b0; motEnPin = 1'b0;
    expectOuts("R10 outputs after unmapped writes", 5'b00010, 5'b00001);
  endtask

  initial begin
    testResetDefaults();
    testStrapHold();
    testFlag();
    testOsc();
    testMot();
    testDischarge();
    testStatusUnmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule